// File: doc/BRIEF.md
# Keyed Watchdog Timer with Software Reset Request

This block watches a running system and pulls a reset line when software stops servicing it. A free-running counter advances once per clock while the watchdog is enabled. Its terminal count is picked by a 3-bit period select, and each step of the select doubles the period. If the count expires, the block issues a reset pulse and records the event in a sticky overflow flag.

Software talks to the block only through a byte-wide key port, as a strobe with a data byte. Two keys are legal, and each is two bytes long. The first key restarts the count. The second key asks for a software reset, and it does so even while the watchdog is disabled. Any other write, or a legal first byte followed by a wrong second byte, is an illegal sequence. An illegal sequence resets the system at once and sets both flags, so a runaway program that scribbles on the key port cannot stay unnoticed.

The reset pulse returns the counter and the key decoder to their idle state. The flags survive that reset, so code that runs after it can find out why the system restarted. The flags are cleared only by the clear input or by the external reset.

Top module: `wdt_keyed`

## Requirements
- R1: After the external reset `rst_n` is released, `wdt_rst`, `ovf_flag` and `sw_flag` are all 0.
- R2: While `enable` is 1 and no service happens, the reset pulse starts exactly 2^(BASE_LOG2+`period_sel`) clock cycles after counting starts, and `ovf_flag` is set in that same cycle. With the default BASE_LOG2 of 14, the periods run from 16K to 2048K cycles.
- R3: While `enable` is 0, the count never expires and no reset pulse comes from the timer.
- R4: Writing byte 0x1E and then byte 0xE1 to the key port restarts the count from zero, so a full period must pass after the second byte before the count expires.
- R5: Writing byte 0x5A and then byte 0xA5 starts a reset pulse in the cycle after the second byte and sets `sw_flag`. `ovf_flag` is left unchanged, and this works with `enable` at 0.
- R6: A first key byte other than 0x1E or 0x5A starts a reset pulse at once and sets both `ovf_flag` and `sw_flag`.
- R7: A legal first byte followed by a second byte that does not complete its own key (anything other than 0xE1 after 0x1E, or anything other than 0xA5 after 0x5A) is treated as an illegal sequence, with the same effect as in R6.
- R8: Every reset pulse lasts exactly RST_CYCLES clock cycles, with RST_CYCLES at least 2 and 4 by default. Key writes made while the pulse is high are ignored.
- R9: Both flags stay set through the reset pulse and afterwards. A one-cycle `flag_clr` clears both of them, and a set event in the same cycle takes precedence over the clear.
- R10: A watchdog reset pulse discards any half-written key and restarts the count from zero. A second key byte written after the pulse is therefore decoded as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External active-low asynchronous reset |
| enable | input | 1 | Watchdog counting enable |
| period_sel | input | 3 | Timeout period select, 2^(BASE_LOG2+sel) cycles |
| key_wr | input | 1 | Key byte write strobe, one cycle per byte |
| key_data | input | 8 | Key byte written with the strobe |
| flag_clr | input | 1 | Clears both status flags |
| wdt_rst | output | 1 | Reset pulse issued by the watchdog |
| ovf_flag | output | 1 | Sticky flag for timer expiry or illegal key |
| sw_flag | output | 1 | Sticky flag for software reset or illegal key |

## Verification
The in-line assertions check several rules on every cycle: the pulse lasts at least two cycles, an expiry, an illegal key or a software-reset key is followed in the next cycle by the pulse and the correct flags, a service restarts the counter, and the flags stay set until they are cleared. The exact timeout length for each period select, the full pulse width, the ignoring of key writes during a pulse, and the discarding of a half-written key are shown only by the bench's directed scenarios. Those scenarios count cycles from a known starting point.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

   localparam logic [7:0] KEY_SVC_A = 8'h1E;
   localparam logic [7:0] KEY_SVC_B = 8'hE1;
   localparam logic [7:0] KEY_SWR_A = 8'h5A;
   localparam logic [7:0] KEY_SWR_B = 8'hA5;

   typedef enum logic [1:0] {
      KS_IDLE    = 2'd0,
      KS_ARM_SVC = 2'd1,
      KS_ARM_SWR = 2'd2
   } key_state_t;

   typedef struct packed {
      logic svc;
      logic swr;
      logic bad;
   } key_evt_t;

endpackage

// File: rtl/wdt_keyed_fsm.sv
module wdt_keyed_fsm
   import wdt_keyed_pkg::*;
#(
   parameter int KEY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             wr_i,
   input  logic [KEY_W-1:0] data_i,
   output key_evt_t         evt_o
);

   generate
      if (KEY_W != 8) begin : g_bad_key_w
         $error("wdt_keyed_fsm: key port must be one byte wide");
      end
   endgenerate

   key_state_t state_q, state_d;
   key_evt_t   evt;
   logic       wr_live;

   assign wr_live = wr_i && !hold_i;

   always_comb begin
      state_d = state_q;
      evt     = '0;
      if (hold_i) begin
         state_d = KS_IDLE;
      end else if (wr_live) begin
         unique case (state_q)
            KS_IDLE: begin
               if (data_i == KEY_SVC_A) begin
                  state_d = KS_ARM_SVC;
               end else if (data_i == KEY_SWR_A) begin
                  state_d = KS_ARM_SWR;
               end else begin
                  evt.bad = 1'b1;
               end
            end
            KS_ARM_SVC: begin
               state_d = KS_IDLE;
               if (data_i == KEY_SVC_B) evt.svc = 1'b1;
               else                     evt.bad = 1'b1;
            end
            KS_ARM_SWR: begin
               state_d = KS_IDLE;
               if (data_i == KEY_SWR_B) evt.swr = 1'b1;
               else                     evt.bad = 1'b1;
            end
            default: begin
               state_d = KS_IDLE;
               evt.bad = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign evt_o = evt;

   AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_o.svc, evt_o.swr, evt_o.bad})); // R6

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |-> (evt_o == '0)); // R8

   AST_SEQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (state_q == KS_IDLE)); // R10

endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
   parameter int BASE_LOG2 = 14,
   parameter int SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             restart_i,
   input  logic             hold_i,
   output logic             expire_o
);

   localparam int NUM_PER = 1 << SEL_W;
   localparam int CNT_W   = BASE_LOG2 + NUM_PER - 1;

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("wdt_keyed_count: BASE_LOG2 must be at least 1");
      end
      if (CNT_W > 40) begin : g_bad_width
         $error("wdt_keyed_count: counter wider than 40 bits");
      end
   endgenerate

   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_PER-1:0] term;

   generate
      for (genvar gi = 0; gi < NUM_PER; gi++) begin : g_term
         localparam logic [CNT_W-1:0] LIM =
            (CNT_W'(1) << (BASE_LOG2 + gi)) - CNT_W'(1);
         assign term[gi] = (cnt_q == LIM);
      end
   endgenerate

   assign expire_o = en_i && !hold_i && !restart_i && term[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold_i || restart_i || !en_i || expire_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_SVC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0)); // R4

   AST_IDLE_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !expire_o); // R3

endmodule

// File: rtl/wdt_keyed_pulse.sv
module wdt_keyed_pulse #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic rst_o
);

   localparam int PW = $clog2(RST_CYCLES + 1);

   generate
      if (RST_CYCLES < 2) begin : g_bad_len
         $error("wdt_keyed_pulse: RST_CYCLES must be at least 2");
      end
   endgenerate

   logic [PW-1:0] pcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (trig_i && (pcnt_q == '0)) begin
         pcnt_q <= PW'(RST_CYCLES);
      end else if (pcnt_q != '0) begin
         pcnt_q <= pcnt_q - PW'(1);
      end
   end

   assign rst_o = (pcnt_q != '0);

   AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |=> rst_o); // R8

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !rst_o) |=> rst_o); // R8

endmodule

// File: rtl/wdt_keyed_flags.sv
module wdt_keyed_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ovf_i,
   input  logic set_sw_i,
   input  logic clr_i,
   output logic ovf_o,
   output logic sw_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o <= 1'b0;
         sw_o  <= 1'b0;
      end else begin
         if (set_ovf_i)  ovf_o <= 1'b1;
         else if (clr_i) ovf_o <= 1'b0;
         if (set_sw_i)   sw_o  <= 1'b1;
         else if (clr_i) sw_o  <= 1'b0;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> ovf_o); // R9

   AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_o && !clr_i) |=> sw_o); // R9

   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_ovf_i && !set_sw_i) |=> (!ovf_o && !sw_o)); // R9

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_keyed_pkg::*;
#(
   parameter int BASE_LOG2  = 14,
   parameter int SEL_W      = 3,
   parameter int KEY_W      = 8,
   parameter int RST_CYCLES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             flag_clr,
   output logic             wdt_rst,
   output logic             ovf_flag,
   output logic             sw_flag
);

   key_evt_t evt;
   logic     expire;
   logic     trig;

   wdt_keyed_fsm #(.KEY_W(KEY_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (wdt_rst),
      .wr_i   (key_wr),
      .data_i (key_data),
      .evt_o  (evt)
   );

   wdt_keyed_count #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (enable),
      .sel_i     (period_sel),
      .restart_i (evt.svc),
      .hold_i    (wdt_rst),
      .expire_o  (expire)
   );

   assign trig = expire || evt.swr || evt.bad;

   wdt_keyed_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (trig),
      .rst_o  (wdt_rst)
   );

   wdt_keyed_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_ovf_i (expire || evt.bad),
      .set_sw_i  (evt.swr || evt.bad),
      .clr_i     (flag_clr),
      .ovf_o     (ovf_flag),
      .sw_o      (sw_flag)
   );

   AST_EXPIRE_RST: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (wdt_rst && ovf_flag)); // R2

   AST_SWR_RST: assert property (@(posedge clk) disable iff (!rst_n)
      evt.swr |=> (wdt_rst && sw_flag)); // R5

   AST_ILLEGAL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      evt.bad |=> (wdt_rst && ovf_flag && sw_flag)); // R6

endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;

   localparam int BASE = 4;
   localparam int RC   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [2:0] period_sel = 3'd0;
   logic       key_wr = 1'b0;
   logic [7:0] key_data = 8'h00;
   logic       flag_clr = 1'b0;
   logic       wdt_rst, ovf_flag, sw_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdt_keyed #(.BASE_LOG2(BASE), .RST_CYCLES(RC)) u_wdt_keyed (
      .clk(clk), .rst_n(rst_n), .enable(enable), .period_sel(period_sel),
      .key_wr(key_wr), .key_data(key_data), .flag_clr(flag_clr),
      .wdt_rst(wdt_rst), .ovf_flag(ovf_flag), .sw_flag(sw_flag)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic key_write(logic [7:0] b);
      @(negedge clk); key_wr = 1'b1; key_data = b;
      @(negedge clk); key_wr = 1'b0;
   endtask

   // entered at the negedge right after the triggering edge
   task automatic check_pulse(string tag);
      for (int i = 0; i < RC; i++) begin
         chk(tag, wdt_rst, 1);
         @(negedge clk);
      end
      chk(tag, wdt_rst, 0);
   endtask

   task automatic clear_flags();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rst", wdt_rst, 0);
      chk("R1 ovf", ovf_flag, 0);
      chk("R1 sw", sw_flag, 0);
   endtask

   task automatic t_timeout(int sel);
      int n = 1 << (BASE + sel);
      @(negedge clk); period_sel = 3'(sel); enable = 1'b1;
      repeat (n - 1) @(negedge clk);
      chk("R2 before expiry", wdt_rst, 0);
      @(negedge clk);
      chk("R2 expiry pulse", wdt_rst, 1);
      chk("R2 ovf set", ovf_flag, 1);
      chk("R2 sw untouched", sw_flag, 0);
      enable = 1'b0;
      check_pulse("R8 pulse width");
      chk("R9 ovf survives pulse", ovf_flag, 1);
      clear_flags();
      chk("R9 ovf cleared", ovf_flag, 0);
   endtask

   task automatic t_disabled();
      @(negedge clk); enable = 1'b0; period_sel = 3'd0;
      for (int i = 0; i < 3 * (1 << BASE); i++) begin
         @(negedge clk);
         if (wdt_rst) begin chk("R3 no pulse when disabled", 1, 0); break; end
      end
      chk("R3 quiet", wdt_rst, 0);
   endtask

   task automatic t_service();
      int n = 1 << BASE;
      @(negedge clk); period_sel = 3'd0; enable = 1'b1;
      repeat (10) @(negedge clk);
      key_write(8'h1E);
      key_write(8'hE1);
      repeat (n - 1) @(negedge clk);
      chk("R4 no expiry after service", wdt_rst, 0);
      @(negedge clk);
      chk("R4 expiry full period after service", wdt_rst, 1);
      enable = 1'b0;
      repeat (RC) @(negedge clk);
      clear_flags();
   endtask

   task automatic t_swr();
      @(negedge clk); enable = 1'b0;
      key_write(8'h5A);
      chk("R5 no pulse after first byte", wdt_rst, 0);
      key_write(8'hA5);
      chk("R5 pulse", wdt_rst, 1);
      chk("R5 sw flag", sw_flag, 1);
      chk("R5 ovf unchanged", ovf_flag, 0);
      key_write(8'h33);   // during pulse: must be ignored
      chk("R8 write during pulse ignored", ovf_flag, 0);
      repeat (RC) @(negedge clk);
      chk("R8 pulse ended", wdt_rst, 0);
      chk("R9 sw flag kept", sw_flag, 1);
      @(negedge clk); flag_clr = 1'b1; key_wr = 1'b1; key_data = 8'h00;
      @(negedge clk); flag_clr = 1'b0; key_wr = 1'b0;
      chk("R9 set wins over clear ovf", ovf_flag, 1);
      chk("R9 set wins over clear sw", sw_flag, 1);
      repeat (RC) @(negedge clk);
      clear_flags();
      chk("R9 clear sw", sw_flag, 0);
   endtask

   task automatic t_illegal(logic [7:0] b, string tag);
      key_write(b);
      chk(tag, wdt_rst, 1);
      chk(tag, ovf_flag, 1);
      chk(tag, sw_flag, 1);
      repeat (RC) @(negedge clk);
      clear_flags();
   endtask

   task automatic t_bad_second();
      key_write(8'h1E);
      chk("R7 first byte quiet", wdt_rst, 0);
      t_illegal(8'h5A, "R7 svc then wrong");
      key_write(8'h5A);
      t_illegal(8'hE1, "R7 swr then wrong");
   endtask

   task automatic t_seq_drop();
      @(negedge clk); enable = 1'b0; period_sel = 3'd0;
      key_write(8'h1E);
      enable = 1'b1;
      repeat (1 << BASE) @(negedge clk);
      chk("R10 expiry with pending key", wdt_rst, 1);
      enable = 1'b0;
      repeat (RC) @(negedge clk);
      clear_flags();
      t_illegal(8'hE1, "R10 key dropped by pulse");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timeout(0);
      t_timeout(1);
      t_timeout(2);
      t_disabled();
      t_service();
      t_swr();
      t_illegal(8'h00, "R6 illegal first byte");
      t_illegal(8'hE1, "R6 second key byte first");
      t_bad_second();
      t_seq_drop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule